// File: doc/BRIEF.md
# Predicated Load-and-Broadcast Unit

This block carries out a vector load that fetches a single scalar from memory and copies it into every enabled lane of a destination vector. The address of the scalar is a base register plus an unsigned immediate. The immediate is scaled by the size of the memory element only, never by the number of lanes. A 4-bit type code selects three things: the memory element size, the lane size, and whether the value is sign-extended or zero-extended.

The block issues one memory request for each accepted operation. It remembers the lane size, the extension mode and the predicate until the memory returns the scalar. It then builds the whole destination vector in one step. Lanes whose predicate bit is clear get zero.

Two conditions suppress the memory request, and each raises its own flag:
- The operation is combined with the first-fault load mode. This combination is illegal.
- The base is the stack pointer, the alignment check is enabled, and the base is not 16-byte aligned.

Top module: `lrb_bcast_unit`

## Requirements
- R1: When a request is accepted, `mem_addr` equals `req_base + (req_imm << mem_size)` for the 6-bit unsigned immediate. The largest offset is therefore 63 times the memory element size.
- R2: `req_dtype` decodes to (lane bytes, memory bytes, signed) as follows:
  - 0=(1,1,u), 1=(2,1,u), 2=(4,1,u), 3=(8,1,u)
  - 4=(8,4,s), 5=(2,2,u), 6=(4,2,u), 7=(8,2,u)
  - 8=(8,2,s), 9=(4,2,s), A=(4,4,u), B=(8,4,u)
  - C=(8,1,s), D=(4,1,s), E=(2,1,s), F=(8,8,u)

  `mem_size` is log2 of the memory bytes: 0=1, 1=2, 2=4, 3=8.
- R3: The returned scalar's low memory-size bytes are sign-extended for signed codes and zero-extended otherwise. The result is then cut to the lane width.
- R4: Lane i, with lane size E bytes, occupies vector bytes i*E to i*E+E-1 (little-endian). The lane is active when predicate bit i*E is set. Every active lane gets the same extended value, and every inactive lane gets zero.
- R5: Each accepted request raises `mem_req_valid` for exactly the cycle in which `req_valid` is high. No request is made while a fault flag is high.
- R6: A request with `req_first_fault` set raises `illegal_flag` in the same cycle, issues no memory request, and produces no vector.
- R7: A request with `req_base_is_sp`, `sp_align_chk_en`, and a nonzero base[3:0] raises `align_fault`, issues no memory request, and produces no vector. If either condition is absent, no fault is raised.
- R8: `vec_valid` pulses high for one cycle, on the clock after a response arrives for a pending request. `vec_data` holds the new vector from that cycle on.
- R9: A response with no pending request is ignored. `vec_valid` stays low and `vec_data` is unchanged.
- R10: During and right after reset, `vec_valid` is 0, `vec_data` is all zero, and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation presented this cycle |
| req_base | input | ADDR_W | Base address |
| req_imm | input | IMM_W | Unsigned immediate, scaled by memory size |
| req_dtype | input | 4 | Type code (R2) |
| req_pred | input | VLEN_BITS/8 | Predicate, one bit per vector byte |
| req_first_fault | input | 1 | Operation requested in first-fault mode |
| req_base_is_sp | input | 1 | Base register is the stack pointer |
| sp_align_chk_en | input | 1 | Stack-pointer alignment checking enabled |
| mem_req_valid | output | 1 | Scalar memory read issued |
| mem_addr | output | ADDR_W | Byte address of the scalar |
| mem_size | output | 2 | log2 of the bytes to read |
| illegal_flag | output | 1 | Illegal first-fault combination |
| align_fault | output | 1 | Stack-pointer misalignment fault |
| mem_rsp_valid | input | 1 | Scalar returned by memory |
| mem_rsp_data | input | 64 | Returned scalar, right-aligned |
| vec_valid | output | 1 | Destination vector written this cycle |
| vec_data | output | VLEN_BITS | Destination vector |

## Verification
The assertions check the following on every cycle:
- the address arithmetic;
- the rule that a memory request never coexists with either fault;
- both fault conditions;
- the one-cycle response-to-vector latency;
- the rule that `vec_valid` stays low and `vec_data` stays frozen when no pending response arrives.

Only the bench's scenarios can show the lane contents. These include the per-code extension, the predicate-to-lane mapping at each lane size, and the zeroing of inactive lanes. The bench computes each expected vector from the type table and the predicate.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

  // Widest memory element and lane, fixed by the type-code table.
  localparam int LRB_ELEM_W = 64;

  typedef struct packed {
    logic [1:0] esz;  // log2 of lane bytes
    logic [1:0] msz;  // log2 of memory bytes
    logic       sgn;  // sign-extend when set
  } lrb_dtype_t;

  function automatic lrb_dtype_t lrb_decode(input logic [3:0] code);
    lrb_dtype_t d;
    case (code)
      4'h0: d = '{esz: 2'd0, msz: 2'd0, sgn: 1'b0};
      4'h1: d = '{esz: 2'd1, msz: 2'd0, sgn: 1'b0};
      4'h2: d = '{esz: 2'd2, msz: 2'd0, sgn: 1'b0};
      4'h3: d = '{esz: 2'd3, msz: 2'd0, sgn: 1'b0};
      4'h4: d = '{esz: 2'd3, msz: 2'd2, sgn: 1'b1};
      4'h5: d = '{esz: 2'd1, msz: 2'd1, sgn: 1'b0};
      4'h6: d = '{esz: 2'd2, msz: 2'd1, sgn: 1'b0};
      4'h7: d = '{esz: 2'd3, msz: 2'd1, sgn: 1'b0};
      4'h8: d = '{esz: 2'd3, msz: 2'd1, sgn: 1'b1};
      4'h9: d = '{esz: 2'd2, msz: 2'd1, sgn: 1'b1};
      4'hA: d = '{esz: 2'd2, msz: 2'd2, sgn: 1'b0};
      4'hB: d = '{esz: 2'd3, msz: 2'd2, sgn: 1'b0};
      4'hC: d = '{esz: 2'd3, msz: 2'd0, sgn: 1'b1};
      4'hD: d = '{esz: 2'd2, msz: 2'd0, sgn: 1'b1};
      4'hE: d = '{esz: 2'd1, msz: 2'd0, sgn: 1'b1};
      default: d = '{esz: 2'd3, msz: 2'd3, sgn: 1'b0};
    endcase
    return d;
  endfunction

  // Extend the low (1 << msz) bytes of raw to the full element width.
  function automatic logic [LRB_ELEM_W-1:0] lrb_extend(
    input logic [LRB_ELEM_W-1:0] raw,
    input logic [1:0]            msz,
    input logic                  sgn
  );
    logic [LRB_ELEM_W-1:0] r;
    case (msz)
      2'd0: r = {{56{sgn & raw[7]}},  raw[7:0]};
      2'd1: r = {{48{sgn & raw[15]}}, raw[15:0]};
      2'd2: r = {{32{sgn & raw[31]}}, raw[31:0]};
      default: r = raw;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lrb_type_decode.sv
module lrb_type_decode
  import lrb_pkg::*;
(
  input  logic [3:0] code_i,
  output lrb_dtype_t info_o
);

  always_comb info_o = lrb_decode(code_i);

endmodule

// File: rtl/lrb_addr_gen.sv
module lrb_addr_gen #(
  parameter int ADDR_W        = 64,
  parameter int IMM_W         = 6,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        msz_i,
  input  logic              base_is_sp_i,
  input  logic              chk_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misalign_o
);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset     = ADDR_W'(imm_i) << msz_i;
    addr_o     = base_i + offset;
    misalign_o = base_is_sp_i & chk_en_i & (base_i[SP_ALIGN_BITS-1:0] != '0);
  end

endmodule

// File: rtl/lrb_lane_fill.sv
module lrb_lane_fill
  import lrb_pkg::*;
#(
  parameter int VBYTES = 32
) (
  input  logic [LRB_ELEM_W-1:0] value_i,
  input  logic [1:0]            esz_i,
  input  logic [VBYTES-1:0]     pred_i,
  output logic [VBYTES*8-1:0]   vec_o
);

  localparam int BIDX_W = $clog2(VBYTES);

  for (genvar g = 0; g < VBYTES; g++) begin : g_byte
    logic [BIDX_W-1:0] head;
    logic [2:0]        off;
    always_comb begin
      head = BIDX_W'(g) & ~((BIDX_W'(1) << esz_i) - BIDX_W'(1));
      off  = 3'(g) & ((3'd1 << esz_i) - 3'd1);
      vec_o[8*g +: 8] = pred_i[head] ? value_i[8*off +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/lrb_bcast_unit.sv
module lrb_bcast_unit
  import lrb_pkg::*;
#(
  parameter int VLEN_BITS     = 256,
  parameter int ADDR_W        = 64,
  parameter int IMM_W         = 6,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_base,
  input  logic [IMM_W-1:0]       req_imm,
  input  logic [3:0]             req_dtype,
  input  logic [VLEN_BITS/8-1:0] req_pred,
  input  logic                   req_first_fault,
  input  logic                   req_base_is_sp,
  input  logic                   sp_align_chk_en,
  output logic                   mem_req_valid,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [1:0]             mem_size,
  output logic                   illegal_flag,
  output logic                   align_fault,
  input  logic                   mem_rsp_valid,
  input  logic [LRB_ELEM_W-1:0]  mem_rsp_data,
  output logic                   vec_valid,
  output logic [VLEN_BITS-1:0]   vec_data
);

  localparam int VBYTES = VLEN_BITS / 8;

  lrb_dtype_t            req_info;
  logic                  misalign;
  logic                  accept;
  logic                  fill_fire;
  logic                  pending_q;
  lrb_dtype_t            ctx_q;
  logic [VBYTES-1:0]     ctx_pred_q;
  logic [LRB_ELEM_W-1:0] ext_val;
  logic [VLEN_BITS-1:0]  vec_next;
  logic                  vec_valid_q;
  logic [VLEN_BITS-1:0]  vec_data_q;

  lrb_type_decode u_dec (
    .code_i (req_dtype),
    .info_o (req_info)
  );

  lrb_addr_gen #(
    .ADDR_W        (ADDR_W),
    .IMM_W         (IMM_W),
    .SP_ALIGN_BITS (SP_ALIGN_BITS)
  ) u_agen (
    .base_i       (req_base),
    .imm_i        (req_imm),
    .msz_i        (req_info.msz),
    .base_is_sp_i (req_base_is_sp),
    .chk_en_i     (sp_align_chk_en),
    .addr_o       (mem_addr),
    .misalign_o   (misalign)
  );

  always_comb begin
    illegal_flag  = req_valid & req_first_fault;
    align_fault   = req_valid & misalign;
    accept        = req_valid & ~illegal_flag & ~align_fault;
    mem_req_valid = accept;
    mem_size      = req_info.msz;
    fill_fire     = mem_rsp_valid & pending_q;
    ext_val       = lrb_extend(mem_rsp_data, ctx_q.msz, ctx_q.sgn);
  end

  lrb_lane_fill #(
    .VBYTES (VBYTES)
  ) u_fill (
    .value_i (ext_val),
    .esz_i   (ctx_q.esz),
    .pred_i  (ctx_pred_q),
    .vec_o   (vec_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q  <= 1'b0;
      ctx_q      <= '0;
      ctx_pred_q <= '0;
    end else if (accept) begin
      pending_q  <= 1'b1;
      ctx_q      <= req_info;
      ctx_pred_q <= req_pred;
    end else if (fill_fire) begin
      pending_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_data_q  <= '0;
    end else begin
      vec_valid_q <= fill_fire;
      if (fill_fire) vec_data_q <= vec_next;
    end
  end

  assign vec_valid = vec_valid_q;
  assign vec_data  = vec_data_q;

endmodule

// File: rtl/lrb_bcast_chk.sv
module lrb_bcast_chk #(
  parameter int VLEN_BITS     = 256,
  parameter int ADDR_W        = 64,
  parameter int IMM_W         = 6,
  parameter int SP_ALIGN_BITS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic [ADDR_W-1:0]    req_base,
  input logic [IMM_W-1:0]     req_imm,
  input logic                 req_first_fault,
  input logic                 req_base_is_sp,
  input logic                 sp_align_chk_en,
  input logic                 mem_req_valid,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [1:0]           mem_size,
  input logic                 illegal_flag,
  input logic                 align_fault,
  input logic                 mem_rsp_valid,
  input logic                 pending,
  input logic                 vec_valid,
  input logic [VLEN_BITS-1:0] vec_data
);

  // R1
  addr_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_addr == req_base + (ADDR_W'(req_imm) << mem_size));

  // R5
  req_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> req_valid && !illegal_flag && !align_fault);

  // R6
  illegal_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_first_fault) |-> illegal_flag && !mem_req_valid);

  // R7
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_base_is_sp && sp_align_chk_en &&
     req_base[SP_ALIGN_BITS-1:0] != '0) |-> align_fault && !mem_req_valid);

  // R8
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && pending) |=> vec_valid);

  // R9
  orphan_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rsp_valid && pending) |=> !vec_valid && $stable(vec_data));

endmodule

bind lrb_bcast_unit lrb_bcast_chk #(
  .VLEN_BITS     (VLEN_BITS),
  .ADDR_W        (ADDR_W),
  .IMM_W         (IMM_W),
  .SP_ALIGN_BITS (SP_ALIGN_BITS)
) u_lrb_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_base        (req_base),
  .req_imm         (req_imm),
  .req_first_fault (req_first_fault),
  .req_base_is_sp  (req_base_is_sp),
  .sp_align_chk_en (sp_align_chk_en),
  .mem_req_valid   (mem_req_valid),
  .mem_addr        (mem_addr),
  .mem_size        (mem_size),
  .illegal_flag    (illegal_flag),
  .align_fault     (align_fault),
  .mem_rsp_valid   (mem_rsp_valid),
  .pending         (pending_q),
  .vec_valid       (vec_valid),
  .vec_data        (vec_data)
);

// File: tb/test_lrb_bcast_unit.sv
module test_lrb_bcast_unit;

  localparam int CLK_PERIOD = 10;
  localparam int VLEN       = 256;
  localparam int VB         = VLEN / 8;

  typedef struct packed {
    logic [3:0]  dt;
    logic [5:0]  imm;
    logic [63:0] base;
    logic [31:0] pred;
    logic [63:0] data;
    logic [63:0] addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TABLE [NV] = '{
    '{4'h0, 6'd3,  64'h1000, 32'hFFFF_FFFF, 64'hFEDC_BA98_8765_4321, 64'h1003},
    '{4'hE, 6'd5,  64'h2000, 32'h5555_5555, 64'h0000_0000_0000_0080, 64'h2005},
    '{4'h5, 6'd2,  64'h3000, 32'h0000_0F0F, 64'h0000_0000_BEEF_9ABC, 64'h3004},
    '{4'h9, 6'd1,  64'h4000, 32'h1111_0011, 64'h0000_0000_0000_8001, 64'h4002},
    '{4'hA, 6'd10, 64'h5000, 32'hF0F0_F0F0, 64'h0000_1234_89AB_CDEF, 64'h5028},
    '{4'h4, 6'd7,  64'h6000, 32'h0101_0101, 64'h0000_0000_9000_0000, 64'h601C},
    '{4'hF, 6'd63, 64'h7000, 32'h0000_0100, 64'hDEAD_BEEF_0123_4567, 64'h71F8},
    '{4'hC, 6'd0,  64'h8000, 32'h0000_0000, 64'h0000_0000_0000_007F, 64'h8000},
    '{4'h3, 6'd4,  64'h8100, 32'hFFFF_FFFF, 64'h0000_0000_0000_00F0, 64'h8104},
    '{4'hD, 6'd1,  64'h8200, 32'h000F_000F, 64'h0000_0000_0000_0085, 64'h8201}
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid, req_first_fault, req_base_is_sp, sp_align_chk_en;
  logic [63:0]     req_base;
  logic [5:0]      req_imm;
  logic [3:0]      req_dtype;
  logic [VB-1:0]   req_pred;
  logic            mem_req_valid, illegal_flag, align_fault;
  logic [63:0]     mem_addr;
  logic [1:0]      mem_size;
  logic            mem_rsp_valid;
  logic [63:0]     mem_rsp_data;
  logic            vec_valid;
  logic [VLEN-1:0] vec_data;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrb_bcast_unit #(.VLEN_BITS(VLEN)) i_lrb_bcast_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_imm(req_imm), .req_dtype(req_dtype), .req_pred(req_pred),
    .req_first_fault(req_first_fault), .req_base_is_sp(req_base_is_sp),
    .sp_align_chk_en(sp_align_chk_en), .mem_req_valid(mem_req_valid),
    .mem_addr(mem_addr), .mem_size(mem_size), .illegal_flag(illegal_flag),
    .align_fault(align_fault), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  // Type table restated as bytes, from R2.
  function automatic int lane_bytes(input logic [3:0] dt);
    case (dt)
      4'h0: return 1;
      4'h1, 4'h5, 4'hE: return 2;
      4'h2, 4'h6, 4'h9, 4'hA, 4'hD: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int mem_bytes(input logic [3:0] dt);
    case (dt)
      4'h0, 4'h1, 4'h2, 4'h3, 4'hC, 4'hD, 4'hE: return 1;
      4'h4, 4'hA, 4'hB: return 4;
      4'hF: return 8;
      default: return 2;
    endcase
  endfunction

  function automatic bit is_signed(input logic [3:0] dt);
    return dt inside {4'h4, 4'h8, 4'h9, 4'hC, 4'hD, 4'hE};
  endfunction

  function automatic logic [VLEN-1:0] expect_vec(input logic [3:0] dt,
      input logic [31:0] pred, input logic [63:0] d);
    int eb = lane_bytes(dt);
    int mb = mem_bytes(dt);
    logic [63:0] v = '0;
    logic [VLEN-1:0] r = '0;
    for (int i = 0; i < 64; i++)
      v[i] = (i < mb*8) ? d[i] : (is_signed(dt) & d[mb*8-1]);
    for (int k = 0; k < VB; k++)
      if (pred[(k/eb)*eb]) r[k*8 +: 8] = v[(k%eb)*8 +: 8];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_first_fault = 0; req_base_is_sp = 0; sp_align_chk_en = 0;
    req_base = '0; req_imm = '0; req_dtype = '0; req_pred = '0;
    mem_rsp_valid = 0; mem_rsp_data = '0;
  endtask

  task automatic run_op(input vec_t t);
    logic [VLEN-1:0] ev = expect_vec(t.dt, t.pred, t.data);
    @(negedge clk);
    req_valid = 1; req_dtype = t.dt; req_imm = t.imm; req_base = t.base;
    req_pred = t.pred;
    #1;
    check(mem_req_valid === 1'b1, "R5 request issued", VLEN'(mem_req_valid), 1);
    check(mem_addr === t.addr, "R1 address", VLEN'(mem_addr), VLEN'(t.addr));
    check(mem_size === 2'($clog2(mem_bytes(t.dt))), "R2 size",
          VLEN'(mem_size), VLEN'($clog2(mem_bytes(t.dt))));
    @(negedge clk);
    req_valid = 0; mem_rsp_valid = 1; mem_rsp_data = t.data;
    #1;
    check(vec_valid === 1'b0, "R8 not early", VLEN'(vec_valid), 0);
    @(negedge clk);
    mem_rsp_valid = 0;
    #1;
    check(vec_valid === 1'b1, "R8 valid", VLEN'(vec_valid), 1);
    check(vec_data === ev, "R3 R4 vector", vec_data, ev);
    @(negedge clk);
    #1;
    check(vec_valid === 1'b0, "R8 pulse", VLEN'(vec_valid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VLEN-1:0] held;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check(vec_valid === 1'b0, "R10 valid in reset", VLEN'(vec_valid), 0);
    check(vec_data === '0, "R10 data in reset", vec_data, '0);
    @(negedge clk);
    rst_n = 1;
    // R10: response straight after reset finds nothing pending
    mem_rsp_valid = 1; mem_rsp_data = 64'h55;
    @(negedge clk);
    mem_rsp_valid = 0;
    #1;
    check(vec_valid === 1'b0 && vec_data === '0, "R10 nothing pending",
          vec_data, '0);

    for (int i = 0; i < NV; i++) run_op(TABLE[i]);

    // R6: first-fault combination
    held = vec_data;
    @(negedge clk);
    req_valid = 1; req_first_fault = 1; req_dtype = 4'h0; req_base = 64'hA000;
    req_pred = '1;
    #1;
    check(illegal_flag === 1'b1, "R6 flag", VLEN'(illegal_flag), 1);
    check(mem_req_valid === 1'b0, "R6 no request", VLEN'(mem_req_valid), 0);
    @(negedge clk);
    req_valid = 0; req_first_fault = 0; mem_rsp_valid = 1; mem_rsp_data = 64'h11;
    @(negedge clk);
    mem_rsp_valid = 0;
    #1;
    check(vec_valid === 1'b0, "R6 no vector", VLEN'(vec_valid), 0);
    check(vec_data === held, "R9 data held", vec_data, held);

    // R7: misaligned stack-pointer base with checking on
    @(negedge clk);
    req_valid = 1; req_base_is_sp = 1; sp_align_chk_en = 1; req_base = 64'h9008;
    #1;
    check(align_fault === 1'b1, "R7 fault", VLEN'(align_fault), 1);
    check(mem_req_valid === 1'b0, "R7 no request", VLEN'(mem_req_valid), 0);
    // R7: checking disabled
    sp_align_chk_en = 0;
    #1;
    check(align_fault === 1'b0 && mem_req_valid === 1'b1, "R7 check off",
          VLEN'(align_fault), 0);
    // R7: aligned base
    sp_align_chk_en = 1; req_base = 64'h9010;
    #1;
    check(align_fault === 1'b0 && mem_req_valid === 1'b1, "R7 aligned",
          VLEN'(align_fault), 0);
    @(negedge clk);
    idle_inputs();
    // complete the accepted aligned request: dtype 0, predicate all ones
    mem_rsp_valid = 1; mem_rsp_data = 64'h3C;
    @(negedge clk);
    mem_rsp_valid = 0;
    #1;
    check(vec_data === {VB{8'h3C}}, "R4 after aligned sp", vec_data, {VB{8'h3C}});

    // R9: orphan response
    held = vec_data;
    @(negedge clk);
    mem_rsp_valid = 1; mem_rsp_data = 64'h99;
    @(negedge clk);
    mem_rsp_valid = 0;
    #1;
    check(vec_valid === 1'b0, "R9 no valid", VLEN'(vec_valid), 0);
    check(vec_data === held, "R9 unchanged", vec_data, held);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule